// File: doc/BRIEF.md
# Configuration Snapshot EEPROM Writer

This block saves a bank of configuration bytes into an external serial EEPROM and appends a checksum after them. A host starts a copy by writing a single command value into an 8-bit control register. The block then captures the configuration image and cuts the image plus checksum into write bursts that never cross an EEPROM page. It passes each burst to an I2C transaction port through a request/acknowledge handshake.

After every accepted burst the block stays silent for a programmed number of clock cycles, because the EEPROM ignores requests during that time while it writes its page internally. The control register reads back a busy code for the whole copy. It then shows a success code or a failure code, so the host only has to poll one register. A NACK from the transaction port ends the copy at once.

Top module: `cfg_snapshot_writer`

## Requirements
- R1: After reset `ctl_rdata` reads 0x00 and `xfer_req` is low.
- R2: A control write of 0x96 while idle starts a copy. A control write of any other value has no effect: `xfer_req` stays low and `ctl_rdata` keeps its previous value.
- R3: From the cycle after the start write until the copy ends, `ctl_rdata` reads 0x96. A further write of 0x96 during a copy does not restart it or change the order of bursts.
- R4: Bursts go out in ascending EEPROM address order starting at address 0. Each burst has length min(PAGE_BYTES − addr mod PAGE_BYTES, bytes remaining), so it ends at or before a page boundary. Burst byte k sits in `xfer_data[8k+7:8k]` and holds the byte for address `xfer_addr`+k.
- R5: Image byte i is `cfg_image[8i+7:8i]` and goes to EEPROM address i. The image is captured in the cycle of the start write, and later changes of `cfg_image` do not alter the bytes sent.
- R6: The byte at address IMG_BYTES is a CRC-8 over image bytes 0 to IMG_BYTES−1 in ascending order. It uses polynomial 0x07 and initial value 0x00, is processed MSB first, and has no final XOR.
- R7: After the cycle in which a burst is acknowledged without NACK, `xfer_req` stays low for exactly WAIT_CYCLES cycles. Then it rises for the next burst, or the copy ends.
- R8: When the final burst has been accepted and its wait has elapsed, `ctl_rdata` reads 0x00.
- R9: If `xfer_nack` is high with `xfer_ack`, the copy stops. `ctl_rdata` reads 0x01 from the next cycle and no further burst is requested.
- R10: While `xfer_req` is high and `xfer_ack` is low, `xfer_req`, `xfer_addr`, `xfer_len` and `xfer_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register read value (0x96 busy, 0x00 ok, 0x01 failed) |
| cfg_image | input | IMG_BYTES*8 | Configuration bytes, byte i in bits 8i+7:8i |
| xfer_req | output | 1 | Burst request to the I2C transaction port |
| xfer_addr | output | ADDR_W | EEPROM word address of the first burst byte |
| xfer_len | output | LEN_W | Number of bytes in the burst (1 to PAGE_BYTES) |
| xfer_data | output | PAGE_BYTES*8 | Burst bytes, byte k in bits 8k+7:8k |
| xfer_ack | input | 1 | One-cycle completion pulse from the port |
| xfer_nack | input | 1 | Qualifies `xfer_ack`: the EEPROM refused the burst |

## Verification
The copy is run with a counting byte pattern, an all-zero image (checksum 0x00) and an all-ones image. Together these separate byte-placement errors from checksum errors. One run changes `cfg_image` and repeats the start command mid-copy, which tells a snapshot apart from a live read and a restart apart from an ignored command. NACKs are injected on a middle burst and on the checksum burst to show that both stop the copy with the failure code. A clean run after a failure shows that the failure state clears. Non-command values written while idle must leave both the port and the register untouched.

// File: rtl/cfg_snap_pkg.sv
// Shared constants, state type and checksum step for the snapshot writer.
package cfg_snap_pkg;
    localparam logic [7:0] CMD_GO    = 8'h96;
    localparam logic [7:0] CODE_OK   = 8'h00;
    localparam logic [7:0] CODE_FAIL = 8'h01;
    localparam logic [7:0] CRC_POLY  = 8'h07;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_HOLD = 2'd2
    } snap_state_t;

    // One byte of CRC-8, MSB first, no reflection.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                             input logic [7:0] data);
        logic [7:0] r;
        r = crc_in ^ data;
        for (int b = 0; b < 8; b++) begin
            r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/cfg_snap_crc.sv
// Combinational CRC-8 over a captured configuration image.
// Assumes the image is held stable by the caller for the whole copy.
module cfg_snap_crc #(
    parameter int IMG_BYTES = 16
) (
    input  logic [IMG_BYTES*8-1:0] image,
    output logic [7:0]             crc
);
    import cfg_snap_pkg::*;

    // Fold every image byte, lowest address first.
    always_comb begin
        crc = 8'h00;
        for (int i = 0; i < IMG_BYTES; i++) begin
            crc = crc8_byte(crc, image[i*8 +: 8]);
        end
    end
endmodule

// File: rtl/cfg_snap_slicer.sv
// Forms the burst that starts at a given EEPROM address: its length up to
// the next page boundary or the end of data, and its packed bytes.
// Assumes PAGE_BYTES is a power of two and the image starts at address 0.
module cfg_snap_slicer #(
    parameter int IMG_BYTES  = 16,
    parameter int PAGE_BYTES = 2,
    parameter int ADDR_W     = 5,
    parameter int LEN_W      = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [IMG_BYTES*8-1:0]  image,
    input  logic [7:0]              crc,
    output logic [LEN_W-1:0]        len,
    output logic [PAGE_BYTES*8-1:0] data
);
    localparam int TOTAL = IMG_BYTES + 1;

    logic [7:0]      mem [TOTAL];
    logic [ADDR_W:0] room;
    logic [ADDR_W:0] remain;

    // Byte store view: image bytes followed by the checksum.
    for (genvar j = 0; j < TOTAL; j++) begin : g_mem
        if (j < IMG_BYTES) begin : g_img
            assign mem[j] = image[j*8 +: 8];
        end else begin : g_crc
            assign mem[j] = crc;
        end
    end

    // Length: distance to the page end, capped by the bytes left.
    always_comb begin
        room   = (ADDR_W+1)'(PAGE_BYTES) - {1'b0, addr & ADDR_W'(PAGE_BYTES-1)};
        remain = (ADDR_W+1)'(TOTAL) - {1'b0, addr};
        len    = (room < remain) ? room[LEN_W-1:0] : remain[LEN_W-1:0];
    end

    // Byte lanes: lane k carries the byte at addr+k.
    for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_lane
        always_comb begin
            data[k*8 +: 8] = 8'h00;
            for (int j = 0; j < TOTAL; j++) begin
                if (int'(addr) + k == j) data[k*8 +: 8] = mem[j];
            end
        end
    end
endmodule

// File: rtl/cfg_snap_timer.sv
// Counts the EEPROM internal write time after an accepted burst.
// done is high in the WAIT_CYCLES-th cycle after start; WAIT_CYCLES >= 1.
module cfg_snap_timer #(
    parameter int WAIT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign done = run && (cnt == CW'(WAIT_CYCLES - 1));

    // Arm on start, count while running, stop at the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (done) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_snapshot_writer.sv
// Top: command decode, burst sequencing and status for saving a
// configuration image plus CRC-8 into a paged serial EEPROM.
// Assumes the transaction port pulses xfer_ack for one cycle per request.
module cfg_snapshot_writer #(
    parameter int IMG_BYTES   = 16,
    parameter int PAGE_BYTES  = 2,
    parameter int WAIT_CYCLES = 20,
    localparam int TOTAL  = IMG_BYTES + 1,
    localparam int ADDR_W = $clog2(TOTAL + 1),
    localparam int LEN_W  = $clog2(PAGE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [7:0]              ctl_wdata,
    output logic [7:0]              ctl_rdata,
    input  logic [IMG_BYTES*8-1:0]  cfg_image,
    output logic                    xfer_req,
    output logic [ADDR_W-1:0]       xfer_addr,
    output logic [LEN_W-1:0]        xfer_len,
    output logic [PAGE_BYTES*8-1:0] xfer_data,
    input  logic                    xfer_ack,
    input  logic                    xfer_nack
);
    import cfg_snap_pkg::*;

    snap_state_t            st;
    logic [IMG_BYTES*8-1:0] img_q;
    logic [ADDR_W-1:0]      addr_q;
    logic                   fail_q;
    logic [7:0]             crc;
    logic [LEN_W-1:0]       blen;
    logic                   go;
    logic                   acc_ok;
    logic                   tmr_done;

    assign go     = ctl_wr && (ctl_wdata == CMD_GO);
    assign acc_ok = (st == ST_SEND) && xfer_ack && !xfer_nack;

    cfg_snap_crc #(.IMG_BYTES(IMG_BYTES)) u_crc (
        .image (img_q),
        .crc   (crc)
    );

    cfg_snap_slicer #(
        .IMG_BYTES (IMG_BYTES),
        .PAGE_BYTES(PAGE_BYTES),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) u_slice (
        .addr  (addr_q),
        .image (img_q),
        .crc   (crc),
        .len   (blen),
        .data  (xfer_data)
    );

    cfg_snap_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc_ok),
        .done  (tmr_done)
    );

    // Sequencer: capture on command, send bursts, wait, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            img_q  <= '0;
            addr_q <= '0;
            fail_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    img_q  <= cfg_image;
                    addr_q <= '0;
                    st     <= ST_SEND;
                end
                ST_SEND: if (xfer_ack) begin
                    if (xfer_nack) begin
                        fail_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        addr_q <= addr_q + ADDR_W'(blen);
                        st     <= ST_HOLD;
                    end
                end
                ST_HOLD: if (tmr_done) begin
                    if (addr_q == ADDR_W'(TOTAL)) begin
                        fail_q <= 1'b0;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_SEND;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port and status outputs follow the sequencer state.
    assign xfer_req  = (st == ST_SEND);
    assign xfer_addr = addr_q;
    assign xfer_len  = blen;
    assign ctl_rdata = (st != ST_IDLE) ? CMD_GO : (fail_q ? CODE_FAIL : CODE_OK);
endmodule

// File: rtl/cfg_snapshot_writer_chk.sv
// Protocol checker for cfg_snapshot_writer, attached by bind below.
module cfg_snapshot_writer_chk #(
    parameter int IMG_BYTES   = 16,
    parameter int PAGE_BYTES  = 2,
    parameter int WAIT_CYCLES = 20,
    parameter int ADDR_W      = 5,
    parameter int LEN_W       = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ctl_wr,
    input logic [7:0]              ctl_wdata,
    input logic [7:0]              ctl_rdata,
    input logic                    xfer_req,
    input logic [ADDR_W-1:0]       xfer_addr,
    input logic [LEN_W-1:0]        xfer_len,
    input logic [PAGE_BYTES*8-1:0] xfer_data,
    input logic                    xfer_ack,
    input logic                    xfer_nack
);
    int   gap_cnt;
    logic armed;

    // Track cycles since the last clean acknowledge within a copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= 0;
            armed   <= 1'b0;
        end else if (xfer_req && xfer_ack && !xfer_nack) begin
            gap_cnt <= 0;
            armed   <= 1'b1;
        end else begin
            if (gap_cnt < WAIT_CYCLES + 8) gap_cnt <= gap_cnt + 1;
            if (ctl_rdata != 8'h96) armed <= 1'b0;
        end
    end

    p_idle_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata != 8'h96 && !(ctl_wr && ctl_wdata == 8'h96)) |=> !xfer_req);

    p_busy_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ctl_rdata == 8'h96);

    p_page_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_len != '0 &&
                      (int'(xfer_addr) % PAGE_BYTES) + int'(xfer_len) <= PAGE_BYTES));

    p_quiet_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !xfer_nack) |=> !xfer_req);

    p_wait_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xfer_req) && armed) |-> gap_cnt == WAIT_CYCLES);

    p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && xfer_nack) |=> (!xfer_req && ctl_rdata == 8'h01));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_addr) &&
                                     $stable(xfer_len) && $stable(xfer_data)));
endmodule

bind cfg_snapshot_writer cfg_snapshot_writer_chk #(
    .IMG_BYTES  (IMG_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .WAIT_CYCLES(WAIT_CYCLES),
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .xfer_req  (xfer_req),
    .xfer_addr (xfer_addr),
    .xfer_len  (xfer_len),
    .xfer_data (xfer_data),
    .xfer_ack  (xfer_ack),
    .xfer_nack (xfer_nack)
);

// File: tb/sim_cfg_snapshot_writer.sv
// Bench: behavioural reference model compared against the block on every clock.
module sim_cfg_snapshot_writer;
    localparam int IMG  = 16;
    localparam int PG   = 2;
    localparam int WC   = 6;
    localparam int TOT  = IMG + 1;
    localparam int AW   = $clog2(TOT + 1);
    localparam int LW   = $clog2(PG + 1);
    localparam int LAT  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [7:0]        ctl_wdata = 8'h00;
    logic [7:0]        ctl_rdata;
    logic [IMG*8-1:0]  cfg_image = '0;
    logic              xfer_req;
    logic [AW-1:0]     xfer_addr;
    logic [LW-1:0]     xfer_len;
    logic [PG*8-1:0]   xfer_data;
    logic              xfer_ack = 1'b0;
    logic              xfer_nack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state.
    int   m_phase = 0;
    int   m_addr  = 0;
    int   m_cnt   = 0;
    int   m_fail  = 0;
    logic [7:0] ref_b [TOT];
    int   bursts  = 0;
    int   nack_at = -1;
    int   lat     = 0;

    always #4 clk = ~clk;

    cfg_snapshot_writer #(.IMG_BYTES(IMG), .PAGE_BYTES(PG), .WAIT_CYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .cfg_image(cfg_image), .xfer_req(xfer_req),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_data(xfer_data),
        .xfer_ack(xfer_ack), .xfer_nack(xfer_nack)
    );

    function automatic int exp_len(int a);
        int room = PG - (a % PG);
        int rem  = TOT - a;
        return (room < rem) ? room : rem;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model: capture snapshot and checksum at start, step phases per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_cnt = 0; m_fail = 0;
        end else begin
            case (m_phase)
                0: if (ctl_wr && ctl_wdata == 8'h96) begin
                    logic [7:0] c;
                    c = 8'h00;
                    for (int i = 0; i < IMG; i++) begin
                        ref_b[i] = cfg_image[i*8 +: 8];
                        c = c ^ ref_b[i];
                        for (int b = 0; b < 8; b++) begin
                            if (c[7]) c = (c << 1) ^ 8'h07;
                            else      c = c << 1;
                        end
                    end
                    ref_b[IMG] = c;
                    m_addr = 0; m_phase = 1;
                end
                1: if (xfer_ack) begin
                    if (xfer_nack) begin m_fail = 1; m_phase = 0; end
                    else begin m_addr += exp_len(m_addr); m_cnt = 0; m_phase = 2; end
                end
                default: if (m_cnt == WC - 1) begin
                    if (m_addr == TOT) begin m_fail = 0; m_phase = 0; end
                    else m_phase = 1;
                end else m_cnt++;
            endcase
        end
    end

    // Per-clock comparison of status and request against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 R8 R9 ctl_rdata", int'(ctl_rdata), (m_phase != 0) ? 'h96 : m_fail);
            check("R7 R10 xfer_req", int'(xfer_req), (m_phase == 1) ? 1 : 0);
        end
    end

    // Responder: acknowledge each request after LAT cycles and check the burst.
    always @(negedge clk) begin
        if (!rst_n) begin
            xfer_ack = 0; xfer_nack = 0; lat = 0;
        end else if (xfer_ack) begin
            xfer_ack = 0; xfer_nack = 0;
        end else if (xfer_req) begin
            lat++;
            if (lat == LAT) begin
                int el;
                lat = 0;
                el = exp_len(m_addr);
                check("R4 xfer_addr", int'(xfer_addr), m_addr);
                check("R4 xfer_len", int'(xfer_len), el);
                for (int k = 0; k < el; k++) begin
                    if (m_addr + k == IMG)
                        check("R6 checksum byte", int'(xfer_data[k*8 +: 8]), int'(ref_b[IMG]));
                    else
                        check("R4 R5 data byte", int'(xfer_data[k*8 +: 8]), int'(ref_b[m_addr+k]));
                end
                xfer_nack = (bursts == nack_at);
                xfer_ack  = 1;
                bursts++;
            end
        end
    end

    task automatic ctl_write(logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0; ctl_wdata = 8'h00;
    endtask

    task automatic wait_idle();
        while (m_phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fill_pattern(int seed, int step);
        for (int i = 0; i < IMG; i++) cfg_image[i*8 +: 8] = 8'((seed + i * step) & 255);
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset ctl_rdata", int'(ctl_rdata), 0);
        check("R1 reset xfer_req", int'(xfer_req), 0);

        // R2: non-command values are ignored while idle.
        ctl_write(8'h00); ctl_write(8'h95); ctl_write(8'h97);
        ctl_write(8'h69); ctl_write(8'hFF);
        repeat (3) @(negedge clk);
        check("R2 ignored write ctl_rdata", int'(ctl_rdata), 0);
        check("R2 ignored write xfer_req", int'(xfer_req), 0);

        // Counting pattern; repeat command and alter image mid-copy (R3, R5).
        fill_pattern(5, 37);
        bursts = 0; nack_at = -1;
        ctl_write(8'h96);
        repeat (2) @(negedge clk);
        ctl_write(8'h96);
        fill_pattern(200, 11);
        wait_idle();
        check("R8 success code", int'(ctl_rdata), 0);
        check("R4 R6 burst count", bursts, 9);

        // All-zero image: checksum 0x00.
        cfg_image = '0;
        bursts = 0;
        ctl_write(8'h96);
        wait_idle();
        check("R6 R8 zero image result", int'(ctl_rdata), 0);

        // All-ones image with NACK on a middle burst.
        cfg_image = '1;
        bursts = 0; nack_at = 3;
        ctl_write(8'h96);
        wait_idle();
        repeat (20) @(negedge clk);
        check("R9 failure code", int'(ctl_rdata), 1);
        check("R9 bursts before stop", bursts, 4);

        // Recovery run after a failure.
        fill_pattern(77, 3);
        bursts = 0; nack_at = -1;
        ctl_write(8'h96);
        wait_idle();
        check("R8 success after failure", int'(ctl_rdata), 0);

        // NACK on the checksum burst.
        fill_pattern(1, 1);
        bursts = 0; nack_at = 8;
        ctl_write(8'h96);
        wait_idle();
        check("R9 failure on checksum burst", int'(ctl_rdata), 1);
        check("R9 R6 bursts issued", bursts, 9);

        repeat (5) @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (R1..) actual=hung expected=finished");
            summary();
        end
    end
endmodule